// File: doc/BRIEF.md
# Route and Filter Result Combiner

This block merges the three lookup outcomes gathered for one packet (a route match, a primary filter match and an auxiliary filter match) into a single forwarding decision. Each outcome carries a hit flag, a priority, an output port or plugin number, a queue identifier and a 48-bit next-hop field. A three-bit valid field says how to read the next-hop field: as a next-hop IP address, a next-hop MAC address or a copy vector.

The route and the primary filter compete on priority. Only filters normally carry a nonzero priority. The auxiliary filter never wins. It can only supply the destination MAC address for a multicast decision. The result is one of four actions:

- drop the packet,
- queue it to a port,
- fan it out as multicast,
- hand it to the control processor. This happens when the address still needs resolving, or when the winning result is malformed.

Results arrive on a valid/ready interface. A lookup word whose done flag is still clear is not taken. The decision leaves through a registered valid/ready output.

Top module: `route_filter_combiner`

## Requirements
- R1: While any of the three done flags is low, in_ready is low and nothing is accepted.
- R2: The primary filter wins only if it hits and either the route misses or the filter priority is strictly greater than the route priority. Otherwise the route wins. out_port, out_qid and out_nh come from the winner.
- R3: If neither the route nor the primary filter hits, out_act is 0 (drop) and out_mac_ok is 0.
- R4: If the winner's valid field is exactly 3'b010 (MAC address, bit 1), out_act is 1 (queue), out_mac equals the winner's next-hop field and out_mac_ok is 1.
- R5: If the winner's valid field is exactly 3'b100 (copy vector, bit 2), out_act is 2 (multicast). When the auxiliary filter hits with valid bit 1 set, its next-hop field is presented on out_mac with out_mac_ok 1. Otherwise out_mac_ok is 0.
- R6: If the winner's valid field is 3'b000 or 3'b001 (IP address, bit 0), out_act is 3 (control processor) and out_err is 0. Any auxiliary result is discarded and out_mac_ok is 0.
- R7: If the winner's valid field has more than one bit set, out_act is 3, out_err is 1 and out_mac_ok is 0.
- R8: While out_valid is high and out_ready is low, all outputs hold their values and in_ready is low.
- R9: After reset, out_valid is 0. An accepted bundle appears on the outputs one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Result bundle present |
| in_ready | output | 1 | Bundle accepted this cycle |
| rt_done | input | 1 | Route lookup complete |
| rt_hit | input | 1 | Route matched |
| rt_pri | input | PRI_W | Route priority |
| rt_port | input | PORT_W | Route port/plugin |
| rt_qid | input | QID_W | Route queue identifier |
| rt_nh | input | NH_W | Route next-hop field |
| rt_vld | input | 3 | Route next-hop valid bits {copy, MAC, IP} |
| pf_done | input | 1 | Primary filter complete |
| pf_hit | input | 1 | Primary filter matched |
| pf_pri | input | PRI_W | Primary filter priority |
| pf_port | input | PORT_W | Primary filter port/plugin |
| pf_qid | input | QID_W | Primary filter queue identifier |
| pf_nh | input | NH_W | Primary filter next-hop field |
| pf_vld | input | 3 | Primary filter valid bits |
| ax_done | input | 1 | Auxiliary filter complete |
| ax_hit | input | 1 | Auxiliary filter matched |
| ax_nh | input | NH_W | Auxiliary next-hop field |
| ax_vld | input | 3 | Auxiliary valid bits |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Decision consumed |
| out_act | output | 2 | 0 drop, 1 queue, 2 multicast, 3 control processor |
| out_err | output | 1 | Malformed winner valid bits |
| out_port | output | PORT_W | Chosen port/plugin |
| out_qid | output | QID_W | Chosen queue identifier |
| out_nh | output | NH_W | Winner next-hop field |
| out_mac | output | NH_W | Destination MAC to use |
| out_mac_ok | output | 1 | out_mac is meaningful |

## Verification
The assertions check four things on every cycle:

- input is refused while a done flag is low;
- a stalled decision stays frozen;
- an error decision always goes to the control processor;
- drop and control-processor decisions never carry a MAC, while queue decisions always do.

The priority arbitration, the choice of action from the valid bits, and the auxiliary MAC substitution for multicast depend on the input values. Only the bench's sweep over hit flags, priorities and all valid-bit codes shows those.

// File: rtl/route_filter_combiner.sv
module route_filter_combiner #(
  parameter int PRI_W  = 8,
  parameter int PORT_W = 4,
  parameter int QID_W  = 17,
  parameter int NH_W   = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              rt_done,
  input  logic              rt_hit,
  input  logic [PRI_W-1:0]  rt_pri,
  input  logic [PORT_W-1:0] rt_port,
  input  logic [QID_W-1:0]  rt_qid,
  input  logic [NH_W-1:0]   rt_nh,
  input  logic [2:0]        rt_vld,
  input  logic              pf_done,
  input  logic              pf_hit,
  input  logic [PRI_W-1:0]  pf_pri,
  input  logic [PORT_W-1:0] pf_port,
  input  logic [QID_W-1:0]  pf_qid,
  input  logic [NH_W-1:0]   pf_nh,
  input  logic [2:0]        pf_vld,
  input  logic              ax_done,
  input  logic              ax_hit,
  input  logic [NH_W-1:0]   ax_nh,
  input  logic [2:0]        ax_vld,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_act,
  output logic              out_err,
  output logic [PORT_W-1:0] out_port,
  output logic [QID_W-1:0]  out_qid,
  output logic [NH_W-1:0]   out_nh,
  output logic [NH_W-1:0]   out_mac,
  output logic              out_mac_ok
);
  localparam logic [1:0] ACT_DROP = 2'd0, ACT_QUEUE = 2'd1, ACT_MCAST = 2'd2, ACT_CP = 2'd3;

  logic all_done, fire, use_pf, any_hit, multi, aux_mac;
  logic [2:0] w_vld;
  logic [1:0] n_act;
  logic n_err, n_mac_ok;
  logic [NH_W-1:0] w_nh, n_mac;

  assign all_done = rt_done & pf_done & ax_done;
  assign in_ready = all_done & (~out_valid | out_ready);
  assign fire     = in_valid & in_ready;

  assign use_pf  = pf_hit & (~rt_hit | (pf_pri > rt_pri));
  assign any_hit = rt_hit | pf_hit;
  assign w_vld   = use_pf ? pf_vld : rt_vld;
  assign w_nh    = use_pf ? pf_nh  : rt_nh;
  assign multi   = (w_vld & (w_vld - 3'd1)) != 3'd0;
  assign aux_mac = ax_hit & ax_vld[1];

  always_comb begin
    n_act = ACT_CP;
    n_err = 1'b0;
    n_mac = '0;
    n_mac_ok = 1'b0;
    if (!any_hit) begin
      n_act = ACT_DROP;
    end else if (multi) begin
      n_err = 1'b1;
    end else if (w_vld[2]) begin
      n_act = ACT_MCAST;
      if (aux_mac) begin
        n_mac = ax_nh;
        n_mac_ok = 1'b1;
      end
    end else if (w_vld[1]) begin
      n_act = ACT_QUEUE;
      n_mac = w_nh;
      n_mac_ok = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_act    <= ACT_DROP;
      out_err    <= 1'b0;
      out_port   <= '0;
      out_qid    <= '0;
      out_nh     <= '0;
      out_mac    <= '0;
      out_mac_ok <= 1'b0;
    end else begin
      if (fire) begin
        out_valid  <= 1'b1;
        out_act    <= n_act;
        out_err    <= n_err;
        out_port   <= use_pf ? pf_port : rt_port;
        out_qid    <= use_pf ? pf_qid : rt_qid;
        out_nh     <= w_nh;
        out_mac    <= n_mac;
        out_mac_ok <= n_mac_ok;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

module route_filter_combiner_chk #(
  parameter int PORT_W = 4,
  parameter int QID_W  = 17,
  parameter int NH_W   = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              rt_done,
  input logic              pf_done,
  input logic              ax_done,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_act,
  input logic              out_err,
  input logic [PORT_W-1:0] out_port,
  input logic [QID_W-1:0]  out_qid,
  input logic [NH_W-1:0]   out_nh,
  input logic [NH_W-1:0]   out_mac,
  input logic              out_mac_ok
);
  assert_wait_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(rt_done && pf_done && ax_done) |-> !in_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_act) && $stable(out_err) &&
      $stable(out_port) && $stable(out_qid) && $stable(out_nh) && $stable(out_mac) &&
      $stable(out_mac_ok)));

  assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_err_to_cp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_act == 2'd3 && !out_mac_ok));

  assert_no_mac_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_act == 2'd0) |-> !out_mac_ok);

  assert_no_mac_cp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_act == 2'd3) |-> !out_mac_ok);

  assert_queue_mac_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_act == 2'd1) |-> (out_mac_ok && out_mac == out_nh));
endmodule

bind route_filter_combiner route_filter_combiner_chk #(
  .PORT_W(PORT_W), .QID_W(QID_W), .NH_W(NH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .rt_done(rt_done), .pf_done(pf_done), .ax_done(ax_done),
  .out_valid(out_valid), .out_ready(out_ready), .out_act(out_act), .out_err(out_err),
  .out_port(out_port), .out_qid(out_qid), .out_nh(out_nh),
  .out_mac(out_mac), .out_mac_ok(out_mac_ok)
);

// File: tb/route_filter_combiner_bench.sv
module route_filter_combiner_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic in_valid = 0, in_ready, out_ready = 1;
  logic rt_done = 1, rt_hit = 0, pf_done = 1, pf_hit = 0, ax_done = 1, ax_hit = 0;
  logic [7:0] rt_pri = 0, pf_pri = 0;
  logic [3:0] rt_port = 0, pf_port = 0;
  logic [16:0] rt_qid = 0, pf_qid = 0;
  logic [47:0] rt_nh = 0, pf_nh = 0, ax_nh = 0;
  logic [2:0] rt_vld = 0, pf_vld = 0, ax_vld = 0;
  logic out_valid, out_err, out_mac_ok;
  logic [1:0] out_act;
  logic [3:0] out_port;
  logic [16:0] out_qid;
  logic [47:0] out_nh, out_mac;

  int checks = 0, errors = 0;
  bit done_run = 0;

  route_filter_combiner u_route_filter_combiner (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic one(input bit rh, input bit ph, input logic [7:0] rp, input logic [7:0] pp,
                     input logic [2:0] rv, input logic [2:0] pv, input int ax);
    bit fw, mul;
    logic [2:0] wv;
    logic [47:0] wn;
    logic [1:0] ea;
    bit ee, eok;
    logic [47:0] em;
    @(negedge clk);
    rt_hit = rh; pf_hit = ph; rt_pri = rp; pf_pri = pp; rt_vld = rv; pf_vld = pv;
    rt_port = 4'h3; pf_port = 4'hA; rt_qid = 17'h00111; pf_qid = 17'h1ABCD;
    rt_nh = 48'h0000_1111_2222 ^ {45'd0, rv}; pf_nh = 48'hAAAA_BBBB_CCCC ^ {45'd0, pv};
    ax_hit = (ax != 0); ax_vld = (ax == 2) ? 3'b010 : 3'b001; ax_nh = 48'h0100_5E00_0042;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    fw = ph && (!rh || pp > rp);
    wv = fw ? pv : rv;
    wn = fw ? pf_nh : rt_nh;
    mul = (wv == 3'b011) || (wv == 3'b101) || (wv == 3'b110) || (wv == 3'b111);
    ee = 0; eok = 0; em = 0;
    if (!(rh || ph)) ea = 0;
    else if (mul) begin ea = 3; ee = 1; end
    else if (wv == 3'b100) begin ea = 2; if (ax == 2) begin eok = 1; em = ax_nh; end end
    else if (wv == 3'b010) begin ea = 1; eok = 1; em = wn; end
    else ea = 3;
    check(out_valid === 1'b1, "R9 latency", {63'd0, out_valid}, 1);
    check(out_act === ea, ea == 0 ? "R3 drop" : mul ? "R7 error" : ea == 1 ? "R4 queue" :
          ea == 2 ? "R5 multicast" : "R6 to cp", {62'd0, out_act}, {62'd0, ea});
    check(out_err === ee, "R7 err flag", {63'd0, out_err}, {63'd0, ee});
    check(out_mac_ok === eok, ea == 2 ? "R5 aux mac" : "R6 mac_ok", {63'd0, out_mac_ok}, {63'd0, eok});
    if (eok) check(out_mac === em, ea == 2 ? "R5 mac" : "R4 mac", {16'd0, out_mac}, {16'd0, em});
    if (rh || ph) begin
      check(out_port === (fw ? 4'hA : 4'h3), "R2 port", {60'd0, out_port}, fw ? 64'hA : 64'h3);
      check(out_qid === (fw ? 17'h1ABCD : 17'h00111), "R2 qid", {47'd0, out_qid},
            fw ? 64'h1ABCD : 64'h111);
      check(out_nh === wn, "R2 nh", {16'd0, out_nh}, {16'd0, wn});
    end
  endtask

  initial begin
    #2_000_000;
    if (!done_run) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] held;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9 reset", {63'd0, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 idle", {63'd0, out_valid}, 0);

    for (int rh = 0; rh < 2; rh++)
      for (int ph = 0; ph < 2; ph++)
        for (int rp = 0; rp < 2; rp++)
          for (int pp = 0; pp < 3; pp++)
            for (int rv = 0; rv < 8; rv++)
              for (int pv = 0; pv < 8; pv++)
                for (int ax = 0; ax < 3; ax++)
                  one(rh[0], ph[0], rp == 0 ? 8'd0 : 8'd3, pp == 0 ? 8'd0 : pp == 1 ? 8'd3 : 8'd7,
                      rv[2:0], pv[2:0], ax);

    // R1: a clear done flag blocks acceptance
    @(negedge clk);
    pf_done = 0; in_valid = 1;
    repeat (3) begin
      @(negedge clk);
      check(in_ready === 1'b0, "R1 ready", {63'd0, in_ready}, 0);
      check(out_valid === 1'b0, "R1 no output", {63'd0, out_valid}, 0);
    end
    pf_done = 1; ax_done = 0;
    @(negedge clk);
    check(in_ready === 1'b0, "R1 aux done", {63'd0, in_ready}, 0);
    ax_done = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_valid === 1'b1, "R1 release", {63'd0, out_valid}, 1);

    // R8: stall holds the decision
    @(negedge clk);
    out_ready = 0;
    rt_hit = 1; pf_hit = 0; rt_vld = 3'b010; rt_nh = 48'h1234_5678_9ABC;
    in_valid = 1;
    @(negedge clk);
    rt_nh = 48'hFFFF_0000_FFFF; rt_vld = 3'b100;
    held = out_mac;
    check(held === 48'h1234_5678_9ABC, "R8 first", {16'd0, held}, 64'h1234_5678_9ABC);
    repeat (3) begin
      @(negedge clk);
      check(in_ready === 1'b0, "R8 ready low", {63'd0, in_ready}, 0);
      check(out_valid === 1'b1 && out_mac === held && out_act === 2'd1, "R8 hold",
            {16'd0, out_mac}, {16'd0, held});
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check(out_act === 2'd2, "R8 next after release", {62'd0, out_act}, 2);
    @(negedge clk);
    check(out_valid === 1'b0, "R8 drained", {63'd0, out_valid}, 0);

    done_run = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule